// File: doc/BRIEF.md
# Bitfield Execution Unit

This unit handles bitfield operations for a 64-bit integer pipeline in which every operation reads at most two registers and writes one. It takes a source operand, a 12-bit field descriptor and a 3-bit operation code. It returns one 64-bit result for any of five operations: unsigned extract, signed extract, make, set and clear. None of these operations reads the destination register. To merge a field into an existing word, software first clears the target field and then ORs in the output of a make operation.

The field descriptor packs a bit offset and a field width into twelve bits. The descriptor comes either from an immediate or from the low twelve bits of a register. A descriptor loaded into a register once can therefore serve several operations in a row. The arithmetic is combinational. A parameter places a single output register behind it, which is present by default, so a result appears one clock after its operands.

Top module: `bitfield_unit`

## Requirements
- R1: The descriptor's bits [11:6] give the field offset and bits [5:0] give the field width. A width code of 0 means a width of 64.
- R2: When `spec_sel_reg_i` is 1, the descriptor is `spec_reg_i[11:0]`, and the upper bits of `spec_reg_i` and the whole of `spec_imm_i` have no effect. When it is 0, the descriptor is `spec_imm_i`.
- R3: Operation 3'b000 (unsigned extract) returns the field's bits moved down to bit 0, with zeros in every bit above the field.
- R4: Operation 3'b001 (signed extract) returns the same low bits as unsigned extract. Every bit above the field is a copy of the field's highest existing bit.
- R5: Operation 3'b010 (make) takes the low `width` bits of the source, shifts them up by `offset`, and clears every bit outside the field.
- R6: Operation 3'b011 (set) returns the source with every bit of the field forced to 1 and every other bit unchanged.
- R7: Operation 3'b100 (clear) returns the source with every bit of the field forced to 0 and every other bit unchanged.
- R8: A field for which offset+width exceeds 64 ends at bit 63. Extract returns only the bits that exist, and make, set and clear never reach bits below the offset.
- R9: Operation codes 3'b101, 3'b110 and 3'b111 return a zero result and drive `illegal_o` to 1. The five valid codes drive `illegal_o` to 0.
- R10: With the output register present, the result and the illegal flag for the inputs of one clock edge appear after that edge. While `rst_ni` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| spec_sel_reg_i | input | 1 | 1 selects the register descriptor, 0 selects the immediate |
| spec_imm_i | input | 12 | Immediate field descriptor |
| spec_reg_i | input | 64 | Register holding a descriptor in its low 12 bits |
| src_i | input | 64 | Source operand |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | High for an unassigned operation code |

## Verification
The descriptor source selection and the truncation of a field at bit 63 can act in the same cycle. That happens when a register descriptor has nonzero upper bits and describes a field that runs past the top of the word. The bench provokes this case with random register descriptors whose upper 52 bits are filled, and with offsets forced to 0 and 63. Each such result is compared with a bit-by-bit reference model that reads only the low twelve bits of the descriptor and drops any field position beyond 63.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [2:0] {
    OP_UEXT = 3'b000,
    OP_SEXT = 3'b001,
    OP_MAKE = 3'b010,
    OP_SET  = 3'b011,
    OP_CLR  = 3'b100
  } bf_op_e;

endpackage

// File: rtl/bf_field_decode.sv
// Picks the descriptor source and turns offset/width into a right-aligned
// mask of the field bits that exist, plus the index of the top one.
module bf_field_decode #(
  parameter int XLEN = 64,
  localparam int OFS_W = $clog2(XLEN),
  localparam int SPEC_W = 2 * OFS_W
) (
  input  logic              spec_sel_reg_i,
  input  logic [SPEC_W-1:0] spec_imm_i,
  input  logic [XLEN-1:0]   spec_reg_i,
  output logic [OFS_W-1:0]  offset_o,
  output logic [XLEN-1:0]   keep_mask_o,
  output logic [OFS_W-1:0]  top_idx_o
);

  localparam int CNT_W = OFS_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(XLEN);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [SPEC_W-1:0] spec;
  logic [OFS_W-1:0]  off;
  logic [OFS_W-1:0]  wid;
  logic [CNT_W-1:0]  eff_w;
  logic [CNT_W-1:0]  avail;
  logic [CNT_W-1:0]  kept_w;
  logic [CNT_W-1:0]  top_sum;
  logic              unused_spec_hi;

  assign unused_spec_hi = ^spec_reg_i[XLEN-1:SPEC_W];

  always_comb begin
    spec        = spec_sel_reg_i ? spec_reg_i[SPEC_W-1:0] : spec_imm_i;
    off         = spec[SPEC_W-1:OFS_W];
    wid         = spec[OFS_W-1:0];
    eff_w       = (wid == '0) ? FULL : {1'b0, wid};
    avail       = FULL - {1'b0, off};
    kept_w      = (eff_w > avail) ? avail : eff_w;
    keep_mask_o = {XLEN{1'b1}} >> (FULL - kept_w);
    top_sum     = {1'b0, off} + kept_w - ONE;
    top_idx_o   = top_sum[OFS_W-1:0];
    offset_o    = off;
  end

endmodule

// File: rtl/bf_datapath.sv
// The five operations on a source word, given the decoded field.
module bf_datapath
  import bf_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int OFS_W = $clog2(XLEN)
) (
  input  logic [2:0]       op_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [XLEN-1:0]  keep_mask_i,
  input  logic [OFS_W-1:0] top_idx_i,
  output logic [XLEN-1:0]  result_o,
  output logic             illegal_o
);

  logic [XLEN-1:0] shifted_down;
  logic [XLEN-1:0] low_field;
  logic [XLEN-1:0] placed_mask;
  logic            field_sign;

  always_comb begin
    shifted_down = src_i >> offset_i;
    low_field    = shifted_down & keep_mask_i;
    placed_mask  = keep_mask_i << offset_i;
    field_sign   = src_i[top_idx_i];
    result_o     = '0;
    illegal_o    = 1'b0;
    case (bf_op_e'(op_i))
      OP_UEXT: result_o = low_field;
      OP_SEXT: result_o = low_field | (field_sign ? ~keep_mask_i : '0);
      OP_MAKE: result_o = (src_i & keep_mask_i) << offset_i;
      OP_SET:  result_o = src_i | placed_mask;
      OP_CLR:  result_o = src_i & ~placed_mask;
      default: illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/bf_out_stage.sv
// Optional output register; a plain wire when OUT_REG is 0.
module bf_out_stage #(
  parameter int W = 65,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (OUT_REG) begin : g_reg
    logic [W-1:0] q_d;
    logic [W-1:0] q_q;

    always_comb q_d = d_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= q_d;
    end

    assign q_o = q_q;
  end else begin : g_wire
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int XLEN = 64,
  parameter bit OUT_REG = 1'b1,
  localparam int OFS_W = $clog2(XLEN),
  localparam int SPEC_W = 2 * OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic              spec_sel_reg_i,
  input  logic [SPEC_W-1:0] spec_imm_i,
  input  logic [XLEN-1:0]   spec_reg_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN-1:0]   result_o,
  output logic              illegal_o
);

  logic [OFS_W-1:0] offset;
  logic [XLEN-1:0]  keep_mask;
  logic [OFS_W-1:0] top_idx;
  logic [XLEN-1:0]  comb_result;
  logic             comb_illegal;
  logic [XLEN:0]    stage_q;

  bf_field_decode #(.XLEN(XLEN)) u_decode (
    .spec_sel_reg_i (spec_sel_reg_i),
    .spec_imm_i     (spec_imm_i),
    .spec_reg_i     (spec_reg_i),
    .offset_o       (offset),
    .keep_mask_o    (keep_mask),
    .top_idx_o      (top_idx)
  );

  bf_datapath #(.XLEN(XLEN)) u_datapath (
    .op_i        (op_i),
    .src_i       (src_i),
    .offset_i    (offset),
    .keep_mask_i (keep_mask),
    .top_idx_i   (top_idx),
    .result_o    (comb_result),
    .illegal_o   (comb_illegal)
  );

  bf_out_stage #(.W(XLEN + 1), .OUT_REG(OUT_REG)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({comb_illegal, comb_result}),
    .q_o    (stage_q)
  );

  assign result_o  = stage_q[XLEN-1:0];
  assign illegal_o = stage_q[XLEN];

endmodule

// File: rtl/bf_unit_checker.sv
module bf_unit_checker #(
  parameter int XLEN = 64,
  parameter bit OUT_REG = 1'b1,
  localparam int OFS_W = $clog2(XLEN),
  localparam int SPEC_W = 2 * OFS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic              spec_sel_reg_i,
  input logic [SPEC_W-1:0] spec_imm_i,
  input logic [XLEN-1:0]   spec_reg_i,
  input logic [XLEN-1:0]   src_i,
  input logic [XLEN-1:0]   result_o,
  input logic              illegal_o
);

  if (OUT_REG) begin : g_props
    logic [SPEC_W-1:0] spec_seen;
    assign spec_seen = spec_sel_reg_i ? spec_reg_i[SPEC_W-1:0] : spec_imm_i;

    assert_reset_quiet_R10: assert property (@(posedge clk_i)
      !rst_ni |=> (result_o == '0 && !illegal_o));

    assert_bad_code_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i > 3'd4) |=> (illegal_o && result_o == '0));

    assert_good_code_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i <= 3'd4) |=> !illegal_o);

    assert_set_keeps_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd3) |=> ((result_o & $past(src_i)) == $past(src_i)));

    assert_clear_adds_none_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd4) |=> ((result_o & ~$past(src_i)) == '0));

    assert_uext_single_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd0 && spec_seen[OFS_W-1:0] == OFS_W'(1)) |=> (result_o[XLEN-1:1] == '0));

    assert_make_whole_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd2 && spec_seen == '0) |=> (result_o == $past(src_i)));
  end

endmodule

bind bitfield_unit bf_unit_checker #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_i           (op_i),
  .spec_sel_reg_i (spec_sel_reg_i),
  .spec_imm_i     (spec_imm_i),
  .spec_reg_i     (spec_reg_i),
  .src_i          (src_i),
  .result_o       (result_o),
  .illegal_o      (illegal_o)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 3 + 12 + 64 + 64;
  localparam int NVEC = 12;

  // {op, descriptor, source, expected}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {3'b000, 12'h54A, 64'h0000_0000_7FE0_0000, 64'h0000_0000_0000_03FF}, // R3 R1 off21 w10
    {3'b010, 12'h04A, 64'h0000_0000_0000_03FF, 64'h0000_0000_0000_07FE}, // R5 off1 w10
    {3'b001, 12'hF08, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF8}, // R4 R8 truncated
    {3'b011, 12'hFC0, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000}, // R6 R8 off63 full
    {3'b100, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}, // R7 R1 width 0
    {3'b000, 12'h000, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0}, // R3 R1 whole word
    {3'b010, 12'hF84, 64'h0000_0000_0000_000F, 64'hC000_0000_0000_0000}, // R5 R8 no wrap
    {3'b001, 12'h108, 64'h0000_0000_0000_07F0, 64'h0000_0000_0000_007F}, // R4 positive
    {3'b001, 12'h108, 64'h0000_0000_0000_0F80, 64'hFFFF_FFFF_FFFF_FFF8}, // R4 negative
    {3'b100, 12'h208, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_00FF}, // R7 off8 w8
    {3'b011, 12'h208, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_FF00}, // R6 off8 w8
    {3'b000, 12'hFC1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001}  // R3 R8 off63 w1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  op_i;
  logic        spec_sel_reg_i;
  logic [11:0] spec_imm_i;
  logic [63:0] spec_reg_i;
  logic [63:0] src_i;
  logic [63:0] result_o;
  logic        illegal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bitfield_unit i_bitfield_unit (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_i           (op_i),
    .spec_sel_reg_i (spec_sel_reg_i),
    .spec_imm_i     (spec_imm_i),
    .spec_reg_i     (spec_reg_i),
    .src_i          (src_i),
    .result_o       (result_o),
    .illegal_o      (illegal_o)
  );

  function automatic logic [64:0] ref_op(input logic [2:0] op, input logic [11:0] spec,
                                         input logic [63:0] src);
    int off;
    int w;
    int last;
    logic [63:0] r;
    r = '0;
    off = int'(spec[11:6]);
    w = (spec[5:0] == 6'd0) ? 64 : int'(spec[5:0]);
    last = 0;
    case (op)
      3'd0, 3'd1: begin
        for (int j = 0; j < 64; j++)
          if (j < w && off + j < 64) begin
            r[j] = src[off + j];
            last = j;
          end
        if (op == 3'd1 && src[off + last])
          for (int j = 0; j < 64; j++) if (j > last) r[j] = 1'b1;
      end
      3'd2: for (int i = 0; i < 64; i++) if (i >= off && i < off + w) r[i] = src[i - off];
      3'd3: begin
        r = src;
        for (int i = 0; i < 64; i++) if (i >= off && i < off + w) r[i] = 1'b1;
      end
      3'd4: begin
        r = src;
        for (int i = 0; i < 64; i++) if (i >= off && i < off + w) r[i] = 1'b0;
      end
      default: return {1'b1, 64'h0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic sel, input logic [11:0] imm,
                       input logic [63:0] rs, input logic [63:0] src);
    @(negedge clk_i);
    op_i = op;
    spec_sel_reg_i = sel;
    spec_imm_i = imm;
    spec_reg_i = rs;
    src_i = src;
    @(posedge clk_i);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [64:0] exp;
    logic [63:0] mid;
    rst_ni = 1'b0;
    op_i = 3'd3;
    spec_sel_reg_i = 1'b0;
    spec_imm_i = 12'h000;
    spec_reg_i = '0;
    src_i = 64'h5555_AAAA_5555_AAAA;

    // R10: outputs held at zero during reset
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 reset result", result_o, 64'h0);
    check("R10 reset illegal", {63'h0, illegal_o}, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][142:140], 1'b0, VEC[k][139:128], 64'hFFFF_FFFF_FFFF_FFFF, VEC[k][127:64]);
      check($sformatf("R1-table entry %0d (R3 R4 R5 R6 R7 R8)", k), result_o, VEC[k][63:0]);
      check($sformatf("R9 legal code entry %0d", k), {63'h0, illegal_o}, 64'h0);
    end

    // R2: register descriptor, upper bits and immediate ignored
    drive(3'd0, 1'b1, 12'h000, 64'hABCD_0000_1234_554A, 64'h0000_0000_7FE0_0000);
    check("R2 register descriptor", result_o, 64'h0000_0000_0000_03FF);
    drive(3'd0, 1'b0, 12'h54A, 64'hFFFF_FFFF_FFFF_F000, 64'h0000_0000_7FE0_0000);
    check("R2 immediate descriptor", result_o, 64'h0000_0000_0000_03FF);

    // R3 then R5: move source bits [30:21] into result bits [10:1]
    drive(3'd0, 1'b0, 12'h54A, '0, 64'hFFFF_FFFF_A5A0_0000 | 64'h0000_0000_2B60_0000);
    mid = result_o;
    exp = ref_op(3'd0, 12'h54A, 64'hFFFF_FFFF_A5A0_0000 | 64'h0000_0000_2B60_0000);
    check("R3 chain extract", mid, exp[63:0]);
    drive(3'd2, 1'b1, 12'hFFF, 64'h0000_0000_0000_004A, mid);
    check("R5 chain make", result_o, {53'h0, exp[9:0], 1'b0});

    // R9: unassigned codes
    for (int c = 5; c < 8; c++) begin
      drive(3'(c), 1'b0, 12'h04A, '0, 64'hFFFF_FFFF_FFFF_FFFF);
      check($sformatf("R9 code %0d result", c), result_o, 64'h0);
      check($sformatf("R9 code %0d flag", c), {63'h0, illegal_o}, 64'h1);
    end

    // random descriptors with boundary offsets, both sources
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  op;
      logic [11:0] spec;
      logic [63:0] src;
      logic        sel;
      op = 3'($urandom_range(0, 7));
      spec = 12'($urandom);
      if (n % 4 == 1) spec[11:6] = 6'd0;
      if (n % 4 == 2) spec[11:6] = 6'd63;
      src = {$urandom, $urandom};
      sel = n[0];
      exp = ref_op(op, spec, src);
      if (sel) drive(op, 1'b1, ~spec, {$urandom, 20'($urandom), spec}, src);
      else     drive(op, 1'b0, spec, {$urandom, $urandom}, src);
      check($sformatf("R8 random op %0d spec %h sel %0d", op, spec, sel), result_o, exp[63:0]);
      check("R9 random flag", {63'h0, illegal_o}, {63'h0, exp[64]});
    end

    // R10: reset mid-run clears outputs
    drive(3'd3, 1'b0, 12'h000, '0, '0);
    check("R10 before reset", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R10 async clear", result_o, 64'h0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule